// File: doc/BRIEF.md
# Diagonal-Trace Velocity Hypothesis Scorer

This block rates a set of candidate velocities for one active pixel against a binary occupancy history. The history holds one bit per position and per age slot. A start strobe carries the pixel index x0. For every integer jump j from -J to +J, the block walks back through the history along a slanted line. At step h it reads the bit at position x0 - j*h in age slot L - h. For each hypothesis it counts two values: the set bits met along the trace, which form the raw score, and the steps that landed inside the valid position range. No multiplier is needed, because the trace position is updated by adding -j once per step.

Two build-time variants give the same results. The parallel variant runs one lane per hypothesis, and all lanes step together. The sequential variant reuses a single lane and takes the hypotheses in ascending order of j. A downstream winner selector reads the per-hypothesis score, step count and eligibility flag after the done pulse.

Top module: `dtrace_scorer`

## Requirements
- R1: Output slot k (k = 0..2J) belongs to jump j = k - J. Its score is at score_o[k*CW +: CW] and its step count at steps_o[k*CW +: CW], with CW = clog2(L+1).
- R2: At step h (1..L), hypothesis j reads history bit hist_i[p*L + (L-h)], with p = x0 - j*h.
- R3: A hypothesis's score equals the number of set history bits read at its in-bounds steps.
- R4: A hypothesis's step count equals the number of steps h for which 0 <= x0 - j*h <= NX-1. Out-of-range steps add to neither count, so trace lengths differ near the edges.
- R5: keep_o[k] is 1 exactly when the step count of slot k is at least min_steps_i; otherwise the hypothesis is discarded.
- R6: done_o is a one-cycle pulse. Counting from the clock edge that samples start_i, it rises L+1 edges later in the parallel variant and NHYP*(L+1) edges later in the sequential variant, where NHYP = 2J+1.
- R7: After reset all scores and step counts read zero and done_o is low. Results stay unchanged from a done pulse until the next start.
- R8: In every lane, the score never exceeds the step count and the step count never exceeds L.
- R9: A start that arrives while scoring is under way abandons the current run. The block then scores from scratch for the new x0, with the latency of R6 counted from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin scoring for x0_i |
| x0_i | input | clog2(NX) | Active pixel index |
| hist_i | input | NX*L | Occupancy history, bit p*L+s is position p, age slot s; held stable while scoring |
| min_steps_i | input | CW | Minimum in-bounds steps for a hypothesis to stay eligible |
| score_o | output | NHYP*CW | Raw score per hypothesis |
| steps_o | output | NHYP*CW | In-bounds step count per hypothesis |
| keep_o | output | NHYP | Eligibility per hypothesis |
| done_o | output | 1 | One-cycle pulse when all results are valid |

## Verification
The bench drives both variants with the same stimulus. It aims at pixels at either edge of the array, where a wrong bounds test would count or read out-of-range steps, or wrap the position back into the array. All-ones and all-zeros histories expose a score that is not tied to in-bounds steps, and a reversed slot order shows up as a mismatch on random histories. The bench also sets the eligibility threshold exactly at a step count, which catches an off-by-one comparison. A restart in mid-run catches a design that keeps stale partial counts or fires done early. The exact done latency is checked for both variants, which catches a lost or extra cycle in the sequential hand-over between hypotheses.

// File: rtl/dtrace_pkg.sv
package dtrace_pkg;
  typedef enum logic {
    LANE_IDLE = 1'b0,
    LANE_RUN  = 1'b1
  } lane_st_e;
endpackage

// File: rtl/dtrace_lane.sv
module dtrace_lane
  import dtrace_pkg::*;
#(
  parameter int NX = 16,
  parameter int L  = 8,
  parameter int J  = 2,
  parameter int JW = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic signed [JW-1:0]       jump_i,
  input  logic [$clog2(NX)-1:0]      x0_i,
  input  logic [NX*L-1:0]            hist_i,
  output logic [$clog2(L+1)-1:0]     score_o,
  output logic [$clog2(L+1)-1:0]     steps_o,
  output logic                       fin_o
);
  localparam int XW = $clog2(NX);
  localparam int SW = $clog2(L);
  localparam int CW = $clog2(L+1);
  localparam int PW = $clog2(NX + J*L + 1) + 1;

  lane_st_e             st_q, st_d;
  logic [SW-1:0]        slot_q, slot_d;
  logic signed [PW-1:0] pos_q, pos_d;
  logic signed [PW-1:0] step_q, step_d;
  logic [CW-1:0]        score_q, score_d;
  logic [CW-1:0]        steps_q, steps_d;
  logic                 fin_q, fin_d;

  logic                 in_rng;
  logic [XW-1:0]        pos_u;
  logic [NX-1:0]        col;
  logic [L-1:0]         row;
  logic                 hit;
  logic signed [PW-1:0] x0_ext;
  logic signed [PW-1:0] jmp_ext;

  always_comb begin
    in_rng = !pos_q[PW-1] && (pos_q < $signed(PW'(NX)));
    pos_u  = pos_q[XW-1:0];
    row    = '0;
    for (int p = 0; p < NX; p++) begin
      row    = hist_i[p*L +: L];
      col[p] = row[slot_q];
    end
    hit = in_rng && col[pos_u];
  end

  always_comb begin
    x0_ext  = $signed({{(PW-XW){1'b0}}, x0_i});
    jmp_ext = PW'(jump_i);
    st_d    = st_q;
    slot_d  = slot_q;
    pos_d   = pos_q;
    step_d  = step_q;
    score_d = score_q;
    steps_d = steps_q;
    fin_d   = 1'b0;
    if (load_i) begin
      st_d    = LANE_RUN;
      slot_d  = SW'(L-1);
      pos_d   = x0_ext - jmp_ext;
      step_d  = -jmp_ext;
      score_d = '0;
      steps_d = '0;
    end else if (st_q == LANE_RUN) begin
      score_d = score_q + CW'(hit);
      steps_d = steps_q + CW'(in_rng);
      pos_d   = pos_q + step_q;
      if (slot_q == '0) begin
        st_d  = LANE_IDLE;
        fin_d = 1'b1;
      end else begin
        slot_d = slot_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= LANE_IDLE;
      slot_q  <= '0;
      pos_q   <= '0;
      step_q  <= '0;
      score_q <= '0;
      steps_q <= '0;
      fin_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      slot_q  <= slot_d;
      pos_q   <= pos_d;
      step_q  <= step_d;
      score_q <= score_d;
      steps_q <= steps_d;
      fin_q   <= fin_d;
    end
  end

  assign score_o = score_q;
  assign steps_o = steps_q;
  assign fin_o   = fin_q;

  // R8
  score_le_steps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    score_q <= steps_q);

  // R8
  steps_le_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steps_q <= CW'(L));

  // R6
  fin_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |=> !fin_q);
endmodule

// File: rtl/dtrace_scorer.sv
module dtrace_scorer
  import dtrace_pkg::*;
#(
  parameter int NX       = 16,
  parameter int L        = 8,
  parameter int J        = 2,
  parameter bit PARALLEL = 1'b1
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 start_i,
  input  logic [$clog2(NX)-1:0]                x0_i,
  input  logic [NX*L-1:0]                      hist_i,
  input  logic [$clog2(L+1)-1:0]               min_steps_i,
  output logic [(2*J+1)*$clog2(L+1)-1:0]       score_o,
  output logic [(2*J+1)*$clog2(L+1)-1:0]       steps_o,
  output logic [2*J:0]                         keep_o,
  output logic                                 done_o
);
  localparam int NHYP = 2*J + 1;
  localparam int CW   = $clog2(L+1);
  localparam int KW   = $clog2(NHYP);
  localparam int JW   = KW + 1;

  logic [NHYP-1:0] wr_en;
  logic [CW-1:0]   wr_sc [NHYP];
  logic [CW-1:0]   wr_st [NHYP];
  logic            last_fin;

  logic [CW-1:0]   res_sc_q [NHYP];
  logic [CW-1:0]   res_st_q [NHYP];
  logic [CW-1:0]   res_sc_d [NHYP];
  logic [CW-1:0]   res_st_d [NHYP];
  logic            done_q, done_d;

  if (PARALLEL) begin : g_par
    logic [NHYP-1:0] fin_v;
    for (genvar k = 0; k < NHYP; k++) begin : g_lane
      logic [CW-1:0] sc, st;
      dtrace_lane #(.NX(NX), .L(L), .J(J), .JW(JW)) lane_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (start_i),
        .jump_i  ($signed(JW'(k)) - $signed(JW'(J))),
        .x0_i    (x0_i),
        .hist_i  (hist_i),
        .score_o (sc),
        .steps_o (st),
        .fin_o   (fin_v[k])
      );
      assign wr_sc[k] = sc;
      assign wr_st[k] = st;
      assign wr_en[k] = |fin_v;
    end
    assign last_fin = |fin_v;
  end else begin : g_seq
    logic [KW-1:0]         idx_q, idx_d;
    logic [KW-1:0]         idx_nxt;
    logic                  fin, adv, lload;
    logic signed [JW-1:0]  jmp;
    logic [CW-1:0]         sc, st;

    always_comb begin
      adv     = fin && (idx_q != KW'(NHYP-1));
      idx_nxt = start_i ? '0 : idx_q + 1'b1;
      lload   = start_i || adv;
      jmp     = $signed(JW'(idx_nxt)) - $signed(JW'(J));
      idx_d   = idx_q;
      if (start_i)  idx_d = '0;
      else if (adv) idx_d = idx_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) idx_q <= '0;
      else         idx_q <= idx_d;
    end

    dtrace_lane #(.NX(NX), .L(L), .J(J), .JW(JW)) lane_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (lload),
      .jump_i  (jmp),
      .x0_i    (x0_i),
      .hist_i  (hist_i),
      .score_o (sc),
      .steps_o (st),
      .fin_o   (fin)
    );

    for (genvar k = 0; k < NHYP; k++) begin : g_wr
      assign wr_sc[k] = sc;
      assign wr_st[k] = st;
      assign wr_en[k] = fin && (idx_q == KW'(k));
    end
    assign last_fin = fin && (idx_q == KW'(NHYP-1));
  end

  always_comb begin
    for (int k = 0; k < NHYP; k++) begin
      res_sc_d[k] = res_sc_q[k];
      res_st_d[k] = res_st_q[k];
      if (wr_en[k] && !start_i) begin
        res_sc_d[k] = wr_sc[k];
        res_st_d[k] = wr_st[k];
      end
    end
    done_d = last_fin && !start_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NHYP; k++) begin
        res_sc_q[k] <= '0;
        res_st_q[k] <= '0;
      end
      done_q <= 1'b0;
    end else begin
      for (int k = 0; k < NHYP; k++) begin
        res_sc_q[k] <= res_sc_d[k];
        res_st_q[k] <= res_st_d[k];
      end
      done_q <= done_d;
    end
  end

  always_comb begin
    for (int k = 0; k < NHYP; k++) begin
      score_o[k*CW +: CW] = res_sc_q[k];
      steps_o[k*CW +: CW] = res_st_q[k];
      keep_o[k]           = res_st_q[k] >= min_steps_i;
    end
  end
  assign done_o = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R8
  result_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (res_sc_q[0] <= res_st_q[0]) && (res_st_q[NHYP-1] <= CW'(L)));
endmodule

// File: tb/dtrace_scorer_tb.sv
`timescale 1ns/1ps
module dtrace_scorer_tb_top;
  localparam int NX    = 16;
  localparam int L     = 8;
  localparam int J     = 2;
  localparam int NHYP  = 2*J + 1;
  localparam int CW    = $clog2(L+1);
  localparam int XW    = $clog2(NX);
  localparam int LAT_P = L + 1;
  localparam int LAT_S = NHYP * (L + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [XW-1:0] x0_r = '0;
  logic [NX*L-1:0] hist_r = '0;
  logic [CW-1:0] min_r = '0;

  logic [NHYP*CW-1:0] sc_p, st_p, sc_s, st_s;
  logic [NHYP-1:0] kp_p, kp_s;
  logic done_p, done_s;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  dtrace_scorer #(.NX(NX), .L(L), .J(J), .PARALLEL(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .x0_i(x0_r), .hist_i(hist_r),
    .min_steps_i(min_r), .score_o(sc_p), .steps_o(st_p), .keep_o(kp_p), .done_o(done_p));

  dtrace_scorer #(.NX(NX), .L(L), .J(J), .PARALLEL(1'b0)) dut_seq_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .x0_i(x0_r), .hist_i(hist_r),
    .min_steps_i(min_r), .score_o(sc_s), .steps_o(st_s), .keep_o(kp_s), .done_o(done_s));

  function automatic void ref_eval(input int x0, input int j, input logic [NX*L-1:0] hv,
                                   output int sc, output int st);
    sc = 0;
    st = 0;
    for (int h = 1; h <= L; h++) begin
      int p;
      p = x0 - j*h;
      if (p >= 0 && p < NX) begin
        st++;
        if (hv[p*L + (L-h)]) sc++;
      end
    end
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < NHYP; k++) begin
      int es, et;
      ref_eval(int'(x0_r), k - J, hist_r, es, et);
      // R1 R2 R3 R4 R5: per-slot score, step count, eligibility
      chk(req, $sformatf("par score k=%0d x0=%0d", k, x0_r), int'(sc_p[k*CW +: CW]), es);
      chk(req, $sformatf("par steps k=%0d x0=%0d", k, x0_r), int'(st_p[k*CW +: CW]), et);
      chk("R5", $sformatf("par keep k=%0d", k), int'(kp_p[k]), int'(et >= int'(min_r)));
      chk(req, $sformatf("seq score k=%0d x0=%0d", k, x0_r), int'(sc_s[k*CW +: CW]), es);
      chk(req, $sformatf("seq steps k=%0d x0=%0d", k, x0_r), int'(st_s[k*CW +: CW]), et);
      chk("R5", $sformatf("seq keep k=%0d", k), int'(kp_s[k]), int'(et >= int'(min_r)));
    end
  endtask

  task automatic launch(input int x0, input logic [NX*L-1:0] hv, input int mn);
    @(negedge clk);
    start  = 1'b1;
    x0_r   = XW'(x0);
    hist_r = hv;
    min_r  = CW'(mn);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int lp, ls;
    lp = -1;
    ls = -1;
    for (int c = 1; c <= LAT_S + 20; c++) begin
      if (done_p && lp < 0) lp = c;
      if (done_s && ls < 0) ls = c;
      if (lp >= 0 && ls >= 0) break;
      @(negedge clk);
    end
    // R6: done visible one sample after the edge that sets it
    chk(req, "parallel done latency", lp, LAT_P + 1);
    chk(req, "sequential done latency", ls, LAT_S + 1);
  endtask

  task automatic run_case(input int x0, input logic [NX*L-1:0] hv, input int mn, input string req);
    launch(x0, hv, mn);
    wait_done("R6");
    check_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [NX*L-1:0] hv;
    void'($urandom(32'd20260707));
    min_r = CW'(1);
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7", "reset done par", int'(done_p), 0);
    chk("R7", "reset done seq", int'(done_s), 0);
    chk("R7", "reset scores par", int'(|sc_p), 0);
    chk("R7", "reset steps seq", int'(|st_s), 0);
    chk("R7", "reset keep par", int'(|kp_p), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: all ones at edges, score equals in-bounds steps (R3 R4)
    run_case(0, '1, 1, "R4");
    run_case(NX-1, '1, 8, "R4");
    run_case(NX/2, '1, 5, "R3");
    // directed: all zeros
    run_case(3, '0, 0, "R3");
    // directed: single bit on diagonal j=+1 at h=3 -> position x0-3, slot L-3 (R2)
    hv = '0;
    hv[(7-3)*L + (L-3)] = 1'b1;
    run_case(7, hv, 3, "R2");
    // threshold exactly at a step count: x0=1, j=-2 reaches 1+2h<16 for h<=7 (R5)
    run_case(1, '1, 7, "R5");
    run_case(1, '1, 8, "R5");

    // R7: results held after done
    repeat (6) @(negedge clk);
    check_all("R7");

    // R9: restart mid-run
    launch(4, {4{$urandom()}}, 2);
    repeat (3) @(negedge clk);
    launch(11, {$urandom(), $urandom(), $urandom(), $urandom()}, 4);
    wait_done("R9");
    check_all("R9");

    // constrained random, mixed densities (R1 R2 R3 R4)
    for (int n = 0; n < 40; n++) begin
      logic [NX*L-1:0] a, b;
      a = {$urandom(), $urandom(), $urandom(), $urandom()};
      b = {$urandom(), $urandom(), $urandom(), $urandom()};
      hv = (n % 2 == 0) ? (a & b) : a;
      run_case(int'($urandom_range(0, NX-1)), hv, int'($urandom_range(0, L)), "R1");
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule